// File: doc/BRIEF.md
# Divider and Programmable Timer Peripheral

This block is a byte-wide, memory-mapped timing peripheral. It has two parts. The first is a hidden free-running divider that counts every system clock cycle; only the divider's top byte can be read. The second is a programmable 8-bit counter. That counter advances on the falling edges of one selectable divider bit. When it passes 0xFF it loads a reload value and sends out a one-cycle interrupt request.

Software reaches the block over a simple register bus: an 8-bit offset, a write strobe and write data. Read data is combinational on the current offset. The divider gives software a coarse time base and a cheap source of entropy. The programmable counter produces periodic interrupts at four selectable rates.

Top module: `divtimer`

Register offsets: 0x04 divider (reads bits 15:8 of the hidden counter), 0x05 programmable counter, 0x06 reload value, 0x07 control. In the control register, bit 2 enables counting and bits 1:0 select the rate.

## Requirements
- R1: While reset is held, and in the first cycle after it, the hidden divider, the programmable counter, the reload value and the control bits are all zero, and the interrupt request is low.
- R2: A read at offset 0x04 returns bits 15:8 of the hidden 16-bit divider. The divider advances by one each clock cycle, so the visible value steps once every 256 cycles.
- R3: A write at offset 0x04 clears all 16 bits of the divider, whatever the data written.
- R4: The divider wraps from 0xFFFF to 0x0000 with no other effect.
- R5: Offsets 0x05 and 0x06 read back the values written. Offset 0x07 reads bits 2:0 as written and bits 7:3 as ones. Every other offset reads 0xFF.
- R6: Control bits 1:0 choose the divider bit that clocks the counter: 00 picks bit 9 (one step per 1024 cycles), 01 picks bit 3 (per 16), 10 picks bit 5 (per 64), 11 picks bit 7 (per 256).
- R7: The counter steps once on each falling edge of (selected divider bit AND control bit 2). With control bit 2 clear and no bus write, the counter holds its value.
- R8: Clearing the divider while the selected bit is high, with counting enabled, steps the counter once. Clearing it while that bit is low does not.
- R9: A step from 0xFF loads the reload value. The interrupt request is high for exactly the one cycle in which the reloaded value first appears.
- R10: A bus write to offset 0x05 in the same cycle as a pending step wins. The written value is stored, the step is lost, and no reload or interrupt happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Overflow interrupt request, one-cycle pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a software write to the programmable counter and an increment produced by a divider edge, including the increment that would overflow the counter. The bench lines up a write to offset 0x05 with the exact cycle whose edge would take the counter from 0xFF to the reload value. It judges the outcome by the stored value and by the absence of any interrupt pulse. The second pair is a divider clear and a falling edge: the bench clears the divider once while the selected bit is high and once while it is low, and expects exactly one extra increment in total.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;
   localparam int RATE_W    = 2;
   localparam int NUM_RATES = 1 << RATE_W;

   // control register layout: enable above the rate code
   typedef struct packed {
      logic              run;
      logic [RATE_W-1:0] rate;
   } tctl_t;

   localparam int CTL_W = $bits(tctl_t);
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [DIV_W-1:0] cnt_o
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel
   import divtimer_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int TAP0  = 9,
   parameter int TAP1  = 3,
   parameter int TAP2  = 5,
   parameter int TAP3  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              en_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              tick_o
);
   localparam int IDX_W = (DIV_W > 1) ? $clog2(DIV_W) : 1;

   function automatic int tap_at(input int code);
      case (code)
         0:       return TAP0;
         1:       return TAP1;
         2:       return TAP2;
         default: return TAP3;
      endcase
   endfunction

   logic [IDX_W-1:0] tap_tbl [NUM_RATES];

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
      if (tap_at(g) < 0 || tap_at(g) >= DIV_W) begin : g_bad
         $error("tmr_edge_sel: tap %0d outside divider width", g);
      end
      assign tap_tbl[g] = IDX_W'(tap_at(g));
   end

   logic sel_now;
   logic sel_q;

   assign sel_now = en_i & div_i[tap_tbl[rate_i]];

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_now;
   end

   // high-to-low of the gated tap
   assign tick_o = sel_q & ~sel_now;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_data_i,
   input  logic [CNT_W-1:0] mod_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (ld_i) begin
            cnt_q <= ld_data_i;
         end else if (tick_i) begin
            if (&cnt_q) begin
               cnt_q <= mod_i;
               irq_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o = cnt_q;
   assign irq_o = irq_q;
endmodule

// File: rtl/divtimer.sv
module divtimer
   import divtimer_pkg::*;
#(
   parameter int              ADDR_W  = 8,
   parameter int              DATA_W  = 8,
   parameter int              DIV_W   = 16,
   parameter logic [ADDR_W-1:0] OFF_DIV = 8'h04,
   parameter logic [ADDR_W-1:0] OFF_CNT = 8'h05,
   parameter logic [ADDR_W-1:0] OFF_MOD = 8'h06,
   parameter logic [ADDR_W-1:0] OFF_CTL = 8'h07,
   parameter int              TAP0    = 9,
   parameter int              TAP1    = 3,
   parameter int              TAP2    = 5,
   parameter int              TAP3    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CTL_W;

   if (DIV_W < DATA_W) begin : g_bad_div
      $error("divtimer: divider narrower than data bus");
   end
   if (DATA_W <= CTL_W) begin : g_bad_data
      $error("divtimer: data bus too narrow for control field");
   end

   logic             wr_div, wr_cnt, wr_mod, wr_ctl;
   logic [DIV_W-1:0] div_cnt;
   logic [DATA_W-1:0] tima_q;
   logic [DATA_W-1:0] tma_q;
   tctl_t            ctl_q;
   logic             tick;

   assign wr_div = bus_we && (bus_addr == OFF_DIV);
   assign wr_cnt = bus_we && (bus_addr == OFF_CNT);
   assign wr_mod = bus_we && (bus_addr == OFF_MOD);
   assign wr_ctl = bus_we && (bus_addr == OFF_CTL);

   tmr_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (wr_div),
      .cnt_o (div_cnt)
   );

   tmr_edge_sel #(
      .DIV_W (DIV_W),
      .TAP0  (TAP0),
      .TAP1  (TAP1),
      .TAP2  (TAP2),
      .TAP3  (TAP3)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (div_cnt),
      .en_i   (ctl_q.run),
      .rate_i (ctl_q.rate),
      .tick_o (tick)
   );

   tmr_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .ld_i      (wr_cnt),
      .ld_data_i (bus_wdata),
      .mod_i     (tma_q),
      .cnt_o     (tima_q),
      .irq_o     (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tma_q <= '0;
         ctl_q <= '0;
      end else begin
         if (wr_mod) tma_q <= bus_wdata;
         if (wr_ctl) ctl_q <= tctl_t'(bus_wdata[CTL_W-1:0]);
      end
   end

   always_comb begin
      if (bus_addr == OFF_DIV)      bus_rdata = div_cnt[DIV_W-1 -: DATA_W];
      else if (bus_addr == OFF_CNT) bus_rdata = tima_q;
      else if (bus_addr == OFF_MOD) bus_rdata = tma_q;
      else if (bus_addr == OFF_CTL) bus_rdata = {{PAD_W{1'b1}}, ctl_q};
      else                          bus_rdata = '1;
   end
endmodule

// File: rtl/divtimer_chk.sv
module divtimer_chk #(
   parameter int              ADDR_W  = 8,
   parameter int              DATA_W  = 8,
   parameter int              DIV_W   = 16,
   parameter logic [ADDR_W-1:0] OFF_DIV = 8'h04,
   parameter logic [ADDR_W-1:0] OFF_CNT = 8'h05,
   parameter logic [ADDR_W-1:0] OFF_CTL = 8'h07
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [DIV_W-1:0]  div_cnt,
   input logic [DATA_W-1:0] tima_q,
   input logic [DATA_W-1:0] tma_q,
   input logic              tick
);
   AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFF_DIV) |=> (div_cnt == '0)); // R3

   AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == OFF_DIV) |=> (div_cnt == DIV_W'($past(div_cnt) + 1'b1))); // R2

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R9

   AST_IRQ_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (tima_q == $past(tma_q))); // R9

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFF_CNT) |=> (tima_q == $past(bus_wdata) && !irq)); // R10

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(bus_we && bus_addr == OFF_CNT)) |=> $stable(tima_q)); // R7

   AST_CTL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFF_CTL) |-> (bus_rdata[DATA_W-1:3] == '1)); // R5
endmodule

bind divtimer divtimer_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .DIV_W   (DIV_W),
   .OFF_DIV (OFF_DIV),
   .OFF_CNT (OFF_CNT),
   .OFF_CTL (OFF_CTL)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .div_cnt   (div_cnt),
   .tima_q    (tima_q),
   .tma_q     (tma_q),
   .tick      (tick)
);

// File: tb/test_divtimer.sv
`timescale 1ns/1ps
module test_divtimer;
   localparam logic [7:0] A_DIV = 8'h04;
   localparam logic [7:0] A_CNT = 8'h05;
   localparam logic [7:0] A_MOD = 8'h06;
   localparam logic [7:0] A_CTL = 8'h07;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   divtimer i_divtimer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
      end
   endtask

   // called at a negedge; consumes one rising edge and returns at the next negedge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(A_DIV, v); chk("R1 divider", v, 8'h00);
      rd(A_CNT, v); chk("R1 counter", v, 8'h00);
      rd(A_MOD, v); chk("R1 reload", v, 8'h00);
      rd(A_CTL, v); chk("R1 control", v, 8'hF8);
      chk("R1 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_div_step();
      logic [7:0] v;
      wr(A_DIV, 8'h00);
      repeat (255) @(negedge clk);
      rd(A_DIV, v); chk("R2 count 255", v, 8'h00);
      @(negedge clk);
      rd(A_DIV, v); chk("R2 count 256", v, 8'h01);
      repeat (256) @(negedge clk);
      rd(A_DIV, v); chk("R2 count 512", v, 8'h02);
   endtask

   task automatic t_div_clear_data();
      logic [7:0] v;
      repeat (700) @(negedge clk);
      wr(A_DIV, 8'h5A);
      rd(A_DIV, v); chk("R3 cleared", v, 8'h00);
      repeat (255) @(negedge clk);
      rd(A_DIV, v); chk("R3 low byte cleared", v, 8'h00);
      @(negedge clk);
      rd(A_DIV, v); chk("R3 restart", v, 8'h01);
   endtask

   task automatic t_div_wrap();
      logic [7:0] v;
      wr(A_DIV, 8'hFF);
      repeat (65535) @(negedge clk);
      rd(A_DIV, v); chk("R4 top", v, 8'hFF);
      @(negedge clk);
      rd(A_DIV, v); chk("R4 wrapped", v, 8'h00);
      rd(A_CNT, v); chk("R4 counter untouched", v, 8'h00);
      chk("R4 no irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_readback();
      logic [7:0] v;
      wr(A_MOD, 8'h3C);
      rd(A_MOD, v); chk("R5 reload", v, 8'h3C);
      wr(A_CTL, 8'h03);
      rd(A_CTL, v); chk("R5 control", v, 8'hFB);
      wr(A_CNT, 8'h77);
      rd(A_CNT, v); chk("R5 counter", v, 8'h77);
      rd(8'h00, v); chk("R5 unmapped 00", v, 8'hFF);
      rd(8'h08, v); chk("R5 unmapped 08", v, 8'hFF);
      rd(8'hFF, v); chk("R5 unmapped FF", v, 8'hFF);
   endtask

   task automatic t_disable();
      logic [7:0] v;
      wr(A_CTL, 8'h01);
      wr(A_CNT, 8'h05);
      repeat (1100) @(negedge clk);
      rd(A_CNT, v); chk("R7 disabled holds", v, 8'h05);
   endtask

   task automatic t_rate(input logic [1:0] code, input int period);
      logic [7:0] v;
      wr(A_CTL, {5'd0, 1'b1, code});
      wr(A_DIV, 8'h00);
      wr(A_CNT, 8'h00);
      repeat (period - 1) @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R6 code %0d before edge", code), v, 8'h00);
      @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R6 code %0d first step", code), v, 8'h01);
      repeat (period) @(negedge clk);
      rd(A_CNT, v); chk($sformatf("R7 code %0d second step", code), v, 8'h02);
   endtask

   task automatic t_overflow();
      logic [7:0] v;
      wr(A_CTL, 8'h05);
      wr(A_MOD, 8'hA0);
      wr(A_DIV, 8'h00);
      wr(A_CNT, 8'hFF);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         chk($sformatf("R9 irq at %0d", k), {7'd0, irq}, (k == 16) ? 8'h01 : 8'h00);
         if (k == 15) begin
            rd(A_CNT, v); chk("R9 before overflow", v, 8'hFF);
         end
         if (k == 16) begin
            rd(A_CNT, v); chk("R9 reloaded", v, 8'hA0);
         end
      end
   endtask

   task automatic t_collision();
      logic [7:0] v;
      int pulses = 0;
      wr(A_CTL, 8'h05);
      wr(A_MOD, 8'hA0);
      wr(A_DIV, 8'h00);
      wr(A_CNT, 8'hFF);
      repeat (15) @(negedge clk);
      wr(A_CNT, 8'h33);
      rd(A_CNT, v); chk("R10 write wins", v, 8'h33);
      chk("R10 no irq", {7'd0, irq}, 8'h00);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (irq) pulses++;
      end
      rd(A_CNT, v); chk("R10 no late step", v, 8'h33);
      chk("R10 no pulse", 8'(pulses), 8'h00);
   endtask

   task automatic t_clear_edge();
      logic [7:0] v;
      wr(A_CTL, 8'h05);
      wr(A_DIV, 8'h00);
      wr(A_CNT, 8'h10);
      repeat (7) @(negedge clk);
      rd(A_CNT, v); chk("R8 before clear", v, 8'h10);
      wr(A_DIV, 8'h00);
      @(negedge clk);
      rd(A_CNT, v); chk("R8 clear on high tap", v, 8'h11);
      @(negedge clk);
      wr(A_DIV, 8'h00);
      @(negedge clk);
      rd(A_CNT, v); chk("R8 clear on low tap", v, 8'h11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_div_step();
      t_div_clear_data();
      t_div_wrap();
      t_readback();
      t_disable();
      t_rate(2'b00, 1024);
      t_rate(2'b01, 16);
      t_rate(2'b10, 64);
      t_rate(2'b11, 256);
      t_overflow();
      t_collision();
      t_clear_edge();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule